// File: doc/BRIEF.md
# Link Event Counter Unit

This unit sits beside one link and counts what happens on it. It holds three independent 44-bit accumulators. Each accumulator is steered by its own control word, which picks an event class and a source within that class. Every clock cycle, the selected source contributes an increment of 0 to 255. That lets a single cycle report bursts, such as several flits or a queue depth, rather than only single pulses.

Three event classes exist:
- **General** lanes can be counted by any accumulator.
- **Occupancy** values can be counted only by accumulator 0.
- **Ring** events can be counted only by accumulator 2.

If a class is chosen on an accumulator that does not accept it, that accumulator simply stops adding.

When an add carries out of the top bit, the accumulator wraps. If its overflow enable is set, the unit also latches a sticky per-accumulator flag and sends a one-cycle notification pulse to the global monitoring controller. A global freeze input stops all counting. Software writes through a simple register port still land while the unit is frozen.

Top module: `lpmon_box`

## Requirements
- R1: After reset, all three accumulators read 0, all control words read 0, the status flags read 0 and `ovf_msg` is low.
- R2: Control word layout is bit 0 count enable, bit 1 overflow enable, bits 3:2 class (0 general, 1 occupancy, 2 ring, 3 none), and bits 6:4 source select. With class general and count enable 1, the accumulator adds the 8-bit lane `evt_inc[8*sel +: 8]` on every clock edge. With count enable 0, it does not change.
- R3: Class occupancy adds `occ_val` each edge on accumulator 0 only. On accumulators 1 and 2 it adds nothing.
- R4: Class ring adds 1 on each edge where `ring_evt[sel[1:0]]` is 1, on accumulator 2 only. On accumulators 0 and 1 it adds nothing.
- R5: Accumulators wrap modulo 2^44. An add that carries out of bit 43 is an overflow.
- R6: An overflow on an accumulator whose overflow enable is 1 sets that accumulator's bit in `box_status` at the same clock edge. The bit stays set until software clears it.
- R7: `ovf_msg` is high for the single cycle that follows each clock edge at which an enabled overflow occurred.
- R8: An overflow on an accumulator whose overflow enable is 0 still wraps the value, but it leaves `box_status` and `ovf_msg` unchanged.
- R9: Writing the status address clears each `box_status` bit whose `wr_data` bit is 1 and leaves the others. An overflow setting a bit at the same edge wins over the clear.
- R10: While `freeze` is 1, no accumulator changes except through a software write.
- R11: A write lands at the next clock edge, including while frozen. A write to an accumulator takes priority over that accumulator's increment at the same edge.
- R12: Register addresses are: accumulator i at i (0 to 2), its control word at 4+i, and status at 7. `rd_data` shows the addressed register in the same cycle, zero-extended to 44 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_inc | input | 64 | Eight general event lanes, 8-bit increment each |
| occ_val | input | 8 | Occupancy increment for this cycle |
| ring_evt | input | 4 | Ring event pulses |
| freeze | input | 1 | Global hold of all accumulators |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 44 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 44 | Addressed register contents |
| ctr_val | output | 132 | Accumulator values, accumulator i at bits 44*i +: 44 |
| box_status | output | 3 | Sticky overflow flags, one per accumulator |
| ovf_msg | output | 1 | One-cycle overflow notification |

## Verification
Each accumulator, control word and status bit changes at the first clock edge after the inputs that cause it. `ovf_msg` is high for the cycle after that same edge, and `rd_data` follows `rd_addr` with no delay. The bench therefore drives inputs on the falling edge and counts the rising edges it lets pass. It samples on the next falling edge: it checks the value exactly at the edge where it becomes due, and then checks again one cycle later for the pulse drop and for sticky hold. Table entries run for four counting edges, so every expected total is four times the per-edge increment.

// File: rtl/lpmon_pkg.sv
package lpmon_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        CLS_GEN  = 2'd0,
        CLS_OCC  = 2'd1,
        CLS_RING = 2'd2,
        CLS_NONE = 2'd3
    } evt_cls_e;

    // bit 0 count enable, bit 1 overflow enable, bits 3:2 class, bits 6:4 select
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        evt_cls_e         cls;
        logic             ovf_en;
        logic             cnt_en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/lpmon_evt_sel.sv
module lpmon_evt_sel
    import lpmon_pkg::*;
#(
    parameter int NUM_EVT    = 8,
    parameter int NUM_RING   = 4,
    parameter int INC_W      = 8,
    parameter bit ALLOW_OCC  = 1'b0,
    parameter bit ALLOW_RING = 1'b0
) (
    input  ctl_t                     ctl,
    input  logic [NUM_EVT*INC_W-1:0] evt_inc,
    input  logic [INC_W-1:0]         occ_val,
    input  logic [NUM_RING-1:0]      ring_evt,
    output logic [INC_W-1:0]         inc
);

    localparam int RSEL_W = (NUM_RING > 1) ? $clog2(NUM_RING) : 1;

    always_comb begin
        inc = '0;
        if (ctl.cnt_en) begin
            case (ctl.cls)
                CLS_GEN:  inc = evt_inc[ctl.sel*INC_W +: INC_W];
                CLS_OCC:  if (ALLOW_OCC) inc = occ_val;
                CLS_RING: if (ALLOW_RING) inc = INC_W'(ring_evt[ctl.sel[RSEL_W-1:0]]);
                default:  inc = '0;
            endcase
        end
    end

endmodule

// File: rtl/lpmon_ctr.sv
module lpmon_ctr #(
    parameter int CTR_W = 44,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic             wr_en,
    input  logic [CTR_W-1:0] wr_data,
    input  logic [INC_W-1:0] inc,
    output logic [CTR_W-1:0] val,
    output logic             carry
);

    typedef struct packed {
        logic [CTR_W-1:0] val;
    } ctr_st_t;

    ctr_st_t       st_d, st_q;
    logic [CTR_W:0] sum;

    always_comb begin
        sum   = {1'b0, st_q.val} + {{(CTR_W-INC_W+1){1'b0}}, inc};
        st_d  = st_q;
        carry = 1'b0;
        if (wr_en) begin
            st_d.val = wr_data;
        end else if (!freeze) begin
            st_d.val = sum[CTR_W-1:0];
            carry    = sum[CTR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;

endmodule

// File: rtl/lpmon_box.sv
module lpmon_box
    import lpmon_pkg::*;
#(
    parameter int NUM_CTR  = 3,
    parameter int CTR_W    = 44,
    parameter int INC_W    = 8,
    parameter int NUM_EVT  = 8,
    parameter int NUM_RING = 4,
    parameter int OCC_CTR  = 0,
    parameter int RING_CTR = 2,
    localparam int SLOT      = 1 << $clog2(NUM_CTR + 1),
    localparam int ADDR_W    = $clog2(2 * SLOT),
    localparam int CTL_BASE  = SLOT,
    localparam int STAT_ADDR = 2 * SLOT - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EVT*INC_W-1:0] evt_inc,
    input  logic [INC_W-1:0]         occ_val,
    input  logic [NUM_RING-1:0]      ring_evt,
    input  logic                     freeze,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CTR_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [CTR_W-1:0]         rd_data,
    output logic [NUM_CTR*CTR_W-1:0] ctr_val,
    output logic [NUM_CTR-1:0]       box_status,
    output logic                     ovf_msg
);

    typedef struct packed {
        ctl_t [NUM_CTR-1:0] ctl;
        logic [NUM_CTR-1:0] status;
        logic               msg;
    } box_st_t;

    box_st_t            st_d, st_q;
    logic [NUM_CTR-1:0] carry;
    logic [NUM_CTR-1:0] ctr_wr;
    logic [CTR_W-1:0]   val [NUM_CTR];

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic [INC_W-1:0] inc;

        assign ctr_wr[i] = wr_en && (wr_addr == ADDR_W'(i));

        lpmon_evt_sel #(
            .NUM_EVT    (NUM_EVT),
            .NUM_RING   (NUM_RING),
            .INC_W      (INC_W),
            .ALLOW_OCC  (i == OCC_CTR),
            .ALLOW_RING (i == RING_CTR)
        ) u_sel (
            .ctl      (st_q.ctl[i]),
            .evt_inc  (evt_inc),
            .occ_val  (occ_val),
            .ring_evt (ring_evt),
            .inc      (inc)
        );

        lpmon_ctr #(
            .CTR_W (CTR_W),
            .INC_W (INC_W)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .freeze  (freeze),
            .wr_en   (ctr_wr[i]),
            .wr_data (wr_data),
            .inc     (inc),
            .val     (val[i]),
            .carry   (carry[i])
        );

        assign ctr_val[i*CTR_W +: CTR_W] = val[i];
    end

    always_comb begin
        logic [NUM_CTR-1:0] set_v;
        logic [NUM_CTR-1:0] clr_v;
        st_d  = st_q;
        set_v = '0;
        clr_v = '0;
        if (wr_en && (wr_addr == ADDR_W'(STAT_ADDR))) clr_v = wr_data[NUM_CTR-1:0];
        for (int i = 0; i < NUM_CTR; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(CTL_BASE + i)))
                st_d.ctl[i] = ctl_t'(wr_data[CTL_W-1:0]);
            set_v[i] = carry[i] & st_q.ctl[i].ovf_en;
        end
        st_d.status = (st_q.status & ~clr_v) | set_v;
        st_d.msg    = |set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_addr == ADDR_W'(i))            rd_data = val[i];
            if (rd_addr == ADDR_W'(CTL_BASE + i)) rd_data = CTR_W'(st_q.ctl[i]);
        end
        if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data = CTR_W'(st_q.status);
    end

    assign box_status = st_q.status;
    assign ovf_msg    = st_q.msg;

endmodule

// File: rtl/lpmon_box_chk.sv
module lpmon_box_chk #(
    parameter int NUM_CTR = 3,
    parameter int CTR_W   = 44,
    parameter int ADDR_W  = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     freeze,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [CTR_W-1:0]         wr_data,
    input logic [NUM_CTR*CTR_W-1:0] ctr_val,
    input logic [NUM_CTR-1:0]       box_status,
    input logic                     ovf_msg
);

    localparam logic [ADDR_W-1:0] STAT_A = {ADDR_W{1'b1}};

    logic [NUM_CTR-1:0] keep;
    assign keep = box_status &
                  ~((wr_en && wr_addr == STAT_A) ? wr_data[NUM_CTR-1:0] : '0);

    // R10: frozen and no write means no accumulator moves
    a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr_en) |=> $stable(ctr_val));

    // R7: a notification always comes with a latched flag
    a_r7_msg_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_msg |-> (box_status != '0));

    // R6: a newly set flag is always accompanied by the notification
    a_r6_new_flag_msg: assert property (@(posedge clk) disable iff (!rst_n)
        ((box_status & ~$past(box_status)) != '0) |-> ovf_msg);

    // R9: flags not cleared by a write stay set
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((box_status & $past(keep)) == $past(keep)));

    // R11: a write to accumulator 0 lands on the next edge
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (ctr_val[CTR_W-1:0] == $past(wr_data)));

endmodule

bind lpmon_box lpmon_box_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze     (freeze),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctr_val    (ctr_val),
    .box_status (box_status),
    .ovf_msg    (ovf_msg)
);

// File: tb/lpmon_box_tb.sv
module lpmon_box_tb;

    localparam int CW = 44;
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   evt_inc = '0;
    logic [7:0]    occ_val = '0;
    logic [3:0]    ring_evt = '0;
    logic          freeze = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic [3*CW-1:0] ctr_val;
    logic [2:0]    box_status;
    logic          ovf_msg;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lpmon_box u_dut (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .occ_val(occ_val),
        .ring_evt(ring_evt), .freeze(freeze), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ctr_val(ctr_val), .box_status(box_status), .ovf_msg(ovf_msg)
    );

    // idx[30:29] cls[28:27] sel[26:24] val[23:16] expected total[15:0]
    localparam logic [30:0] TBL [9] = '{
        {2'd0, 2'd0, 3'd2, 8'd5,   16'd20},
        {2'd1, 2'd0, 3'd7, 8'd255, 16'd1020},
        {2'd2, 2'd0, 3'd0, 8'd1,   16'd4},
        {2'd0, 2'd1, 3'd0, 8'd9,   16'd36},
        {2'd1, 2'd1, 3'd0, 8'd9,   16'd0},
        {2'd2, 2'd1, 3'd0, 8'd7,   16'd0},
        {2'd2, 2'd2, 3'd3, 8'd0,   16'd4},
        {2'd0, 2'd2, 3'd1, 8'd0,   16'd0},
        {2'd1, 2'd3, 3'd0, 8'd50,  16'd0}
    };

    task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [CW-1:0] cval(input int i);
        return ctr_val[i*CW +: CW];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [CW-1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctr0", cval(0), '0);
        chk("R1 ctr1", cval(1), '0);
        chk("R1 ctr2", cval(2), '0);
        chk("R1 status", CW'(box_status), '0);
        chk("R1 msg", CW'(ovf_msg), '0);
        rd(3'd5, r); chk("R1 ctl1", r, '0);

        // table: R2 R3 R4 class routing
        for (int k = 0; k < 9; k++) begin
            logic [30:0] e;
            int idx;
            e = TBL[k];
            idx = int'(e[30:29]);
            reg_wr(3'(idx), '0);
            reg_wr(3'(4 + idx), CW'({e[26:24], e[28:27], 1'b0, 1'b1}));
            for (int j = 0; j < 8; j++)
                evt_inc[j*8 +: 8] = (j == int'(e[26:24])) ? e[23:16] : 8'd3;
            occ_val = e[23:16];
            ring_evt = (e[28:27] == 2'd2) ? 4'(4'b1 << e[25:24]) : 4'b0;
            repeat (4) @(negedge clk);
            evt_inc = '0; occ_val = '0; ring_evt = '0;
            reg_wr(3'(4 + idx), '0);
            chk($sformatf("table entry %0d (R2 R3 R4)", k), cval(idx), CW'(e[15:0]));
        end

        // R2 count enable 0 stops counting
        reg_wr(3'd1, 44'd0);
        reg_wr(3'd5, 44'h000);
        evt_inc = {8{8'd9}};
        repeat (3) @(negedge clk);
        evt_inc = '0;
        chk("R2 disabled", cval(1), '0);

        // R12 control word readback
        reg_wr(3'd6, 44'h53);
        rd(3'd6, r); chk("R12 ctl2 read", r, 44'h53);
        reg_wr(3'd6, '0);

        // R5 R6 R7 enabled overflow on accumulator 0
        reg_wr(3'd0, TOP - 44'd9);
        reg_wr(3'd4, 44'h3);
        evt_inc[7:0] = 8'd20;
        @(negedge clk);
        evt_inc = '0;
        chk("R5 wrap", cval(0), 44'd10);
        chk("R6 flag set", CW'(box_status), 44'd1);
        chk("R7 msg high", CW'(ovf_msg), 44'd1);
        @(negedge clk);
        chk("R7 msg drops", CW'(ovf_msg), 44'd0);
        chk("R6 flag sticky", CW'(box_status), 44'd1);

        // R8 overflow without enable on accumulator 1
        reg_wr(3'd1, TOP);
        reg_wr(3'd5, 44'h1);
        evt_inc[7:0] = 8'd1;
        @(negedge clk);
        evt_inc = '0;
        chk("R8 wrap", cval(1), 44'd0);
        chk("R8 flag unchanged", CW'(box_status), 44'd1);
        chk("R8 no msg", CW'(ovf_msg), 44'd0);
        reg_wr(3'd5, '0);

        // R9 write-one-to-clear
        reg_wr(3'd7, 44'd2);
        chk("R9 zero bits keep", CW'(box_status), 44'd1);
        rd(3'd7, r); chk("R12 status read", r, 44'd1);
        reg_wr(3'd7, 44'd1);
        chk("R9 clear", CW'(box_status), 44'd0);

        // R9 set wins over simultaneous clear
        reg_wr(3'd0, TOP);
        evt_inc[7:0] = 8'd1;
        reg_wr(3'd7, 44'd1);
        evt_inc = '0;
        chk("R9 set wins", CW'(box_status), 44'd1);
        reg_wr(3'd4, '0);
        reg_wr(3'd7, 44'd7);

        // R10 R11 freeze behaviour
        reg_wr(3'd0, 44'd100);
        reg_wr(3'd4, 44'h1);
        freeze = 1'b1;
        evt_inc[7:0] = 8'd7;
        repeat (3) @(negedge clk);
        chk("R10 frozen hold", cval(0), 44'd100);
        reg_wr(3'd0, 44'd555);
        chk("R11 write while frozen", cval(0), 44'd555);
        freeze = 1'b0;
        @(negedge clk);
        chk("R10 resumes", cval(0), 44'd562);
        reg_wr(3'd0, 44'd1000);
        chk("R11 write beats increment", cval(0), 44'd1000);
        @(negedge clk);
        evt_inc = '0;
        chk("R11 counts after write", cval(0), 44'd1007);
        reg_wr(3'd4, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule